// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block is the column-side burst engine of a synchronous graphics memory. A 7-bit configuration word sets three things: how many columns a read burst covers, whether the columns advance by incrementing or by flipping low address bits, and how many clocks pass between a read command and the first read data. A read command carries an 8-bit starting column. From the following cycle the block emits one column address per clock, and it raises a data-valid strobe that is delayed to match the programmed read latency.

A full-page setting keeps the column moving, wrapping modulo 256, until a stop request or a new read command ends it. The configuration word can only be changed while no burst is in flight. Reserved or inconsistent settings, and attempts to reprogram the word during a burst, are reported on an error output.

Top module: `burst_col_seq`

## Requirements
- R1: `mode_load` is accepted only when the block is idle: no column is being emitted, no strobe is still pending in the latency pipe, and `rd_cmd` is low in the same cycle. A refused load leaves the stored word unchanged and drives `cfg_error` high for exactly the next cycle.
- R2: The configuration word is laid out as bits 6..4 read latency, bit 3 ordering (0 incrementing, 1 interleaved), and bits 2..0 burst length (000 = 1, 001 = 2, 010 = 4, 011 = 8, 111 = full page).
- R3: An accepted read command drives `col_valid` high from the next cycle for exactly the burst length. The k-th address in incrementing order is (start + k) mod 256.
- R4: In interleaved order the k-th address is the start column XOR k over the low 2 bits for length 4, or over the low 3 bits for length 8. The upper bits stay unchanged.
- R5: In full-page mode the address keeps incrementing modulo 256 past 255 and beyond 256 beats, until it is stopped.
- R6: `burst_stop` sampled high without `rd_cmd` ends the burst, so `col_valid` is low from the next cycle.
- R7: A read command during a burst aborts it. The new start column appears on the next cycle, and this takes priority over a simultaneous `burst_stop`.
- R8: `data_valid` repeats `col_valid` delayed by latency−1 cycles, so the first strobe comes exactly latency cycles after the command edge, for latencies 1, 2 and 3.
- R9: `cfg_error` is high while the stored word is illegal: latency code 000 or 1xx, a burst-length code outside the listed five, or interleaved order with a length other than 4 or 8. While the word is illegal, read commands are ignored.
- R10: After reset the stored word is 0x10 (latency 1, incrementing, length 1), and `col_valid`, `data_valid` and `cfg_error` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Request to store `mode_word` |
| mode_word | input | 7 | Configuration word (latency, ordering, length) |
| rd_cmd | input | 1 | Read command, starts a burst |
| start_col | input | 8 | Starting column of the read |
| burst_stop | input | 1 | Ends the running burst |
| col_addr | output | 8 | Current column address |
| col_valid | output | 1 | `col_addr` holds a burst beat |
| data_valid | output | 1 | Latency-aligned read data strobe |
| cfg_error | output | 1 | Illegal stored word or refused load |

## Verification
The hardest state to reach is a load attempt that arrives while the latency pipe still holds strobes from an earlier burst, or in the same cycle as a read. The test must show that the old latency and ordering survive these attempts. To get there, the bench runs a latency-3 full-page burst and issues a load in mid-burst. It also issues a load together with a read while idle, then starts a fresh burst and checks its strobe timing and address order against the original word. Sweeps over every legal latency, order and length, with start columns near 255, cover the wrap points. A pass over all 128 configuration words covers the error decode.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int MODE_W = 7;

    localparam logic [2:0] BL_ONE  = 3'b000;
    localparam logic [2:0] BL_TWO  = 3'b001;
    localparam logic [2:0] BL_FOUR = 3'b010;
    localparam logic [2:0] BL_EIGHT = 3'b011;
    localparam logic [2:0] BL_FULL = 3'b111;

    typedef struct packed {
        logic [2:0] lat;
        logic       inter;
        logic [2:0] blen;
    } mode_t;

    function automatic logic lat_ok(input logic [2:0] code);
        return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
    endfunction

    function automatic logic [3:0] last_beat(input logic [2:0] code);
        logic [3:0] r;
        case (code)
            BL_TWO:   r = 4'd1;
            BL_FOUR:  r = 4'd3;
            BL_EIGHT: r = 4'd7;
            default:  r = 4'd0;
        endcase
        return r;
    endfunction

    function automatic logic blen_ok(input logic [2:0] code, input logic inter);
        logic r;
        if (inter) r = (code == BL_FOUR) || (code == BL_EIGHT);
        else       r = (code == BL_ONE) || (code == BL_TWO) || (code == BL_FOUR) ||
                       (code == BL_EIGHT) || (code == BL_FULL);
        return r;
    endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
    import bcs_pkg::*;
#(
    parameter logic [MODE_W-1:0] RESET_MODE = 7'h10
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  mode_t word_i,
    input  logic  busy_i,
    input  logic  rd_i,
    output mode_t mode_o,
    output logic  illegal_o,
    output logic  refused_o
);

    typedef struct packed {
        mode_t mode;
        logic  refused;
    } mreg_t;

    mreg_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.refused = 1'b0;
        if (load_i) begin
            if (busy_i || rd_i) st_d.refused = 1'b1;
            else                st_d.mode    = word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode    <= mode_t'(RESET_MODE);
            st_q.refused <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = st_q.mode;
    assign refused_o = st_q.refused;
    assign illegal_o = !lat_ok(st_q.mode.lat) || !blen_ok(st_q.mode.blen, st_q.mode.inter);

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [COL_W-1:0] start_i,
    input  logic             stop_i,
    input  logic             inter_i,
    input  logic [2:0]       blen_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o
);

    typedef struct packed {
        logic             active;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] cnt;
        logic [COL_W-1:0] col;
    } agen_t;

    agen_t st_d, st_q;

    logic [COL_W-1:0] last;
    logic [COL_W-1:0] nxt;
    logic             full;
    logic             at_end;

    always_comb begin
        last   = COL_W'(last_beat(blen_i));
        full   = (blen_i == BL_FULL);
        nxt    = st_q.cnt + 1'b1;
        at_end = !full && (st_q.cnt == last);

        st_d = st_q;
        if (go_i) begin
            st_d.active = 1'b1;
            st_d.base   = start_i;
            st_d.cnt    = '0;
            st_d.col    = start_i;
        end else if (st_q.active) begin
            if (stop_i || at_end) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = nxt;
                if (inter_i) st_d.col = st_q.base ^ (nxt & last);
                else         st_d.col = st_q.base + nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col_o   = st_q.col;
    assign valid_o = st_q.active;

endmodule

// File: rtl/bcs_lat_pipe.sv
module bcs_lat_pipe #(
    parameter int MAX_LAT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_i,
    input  logic [2:0] lat_i,
    output logic       out_o,
    output logic       pending_o
);

    localparam int STAGES = MAX_LAT - 1;

    generate
        if (STAGES > 0) begin : g_pipe
            logic [STAGES-1:0] pipe_d, pipe_q;

            always_comb begin
                pipe_d[0] = in_i;
                for (int s = 1; s < STAGES; s++) pipe_d[s] = pipe_q[s-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= pipe_d;
            end

            always_comb begin
                out_o = 1'b0;
                if (lat_i == 3'd1) out_o = in_i;
                for (int s = 0; s < STAGES; s++)
                    if (lat_i == 3'(s + 2)) out_o = pipe_q[s];
            end

            assign pending_o = |pipe_q;
        end else begin : g_direct
            assign out_o     = in_i && (lat_i == 3'd1);
            assign pending_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W   = 8,
    parameter int MAX_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_load,
    input  logic [6:0]       mode_word,
    input  logic             rd_cmd,
    input  logic [COL_W-1:0] start_col,
    input  logic             burst_stop,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             data_valid,
    output logic             cfg_error
);

    mode_t mode_q;
    logic  cfg_illegal;
    logic  load_refused;
    logic  pending;
    logic  busy;
    logic  rd_go;

    assign busy  = col_valid || pending;
    assign rd_go = rd_cmd && !cfg_illegal;

    bcs_mode_reg #(.RESET_MODE(7'h10)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (mode_load),
        .word_i   (mode_t'(mode_word)),
        .busy_i   (busy),
        .rd_i     (rd_cmd),
        .mode_o   (mode_q),
        .illegal_o(cfg_illegal),
        .refused_o(load_refused)
    );

    bcs_addr_gen #(.COL_W(COL_W)) u_agen (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (rd_go),
        .start_i(start_col),
        .stop_i (burst_stop),
        .inter_i(mode_q.inter),
        .blen_i (mode_q.blen),
        .col_o  (col_addr),
        .valid_o(col_valid)
    );

    bcs_lat_pipe #(.MAX_LAT(MAX_LAT)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_i     (col_valid),
        .lat_i    (mode_q.lat),
        .out_o    (data_valid),
        .pending_o(pending)
    );

    assign cfg_error = cfg_illegal || load_refused;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_load,
    input logic             rd_cmd,
    input logic [COL_W-1:0] start_col,
    input logic             burst_stop,
    input logic [COL_W-1:0] col_addr,
    input logic             col_valid,
    input logic             data_valid,
    input logic             cfg_error,
    input logic [2:0]       lat,
    input logic             ilv,
    input logic             illegal
);

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && $past(col_valid) && !$past(rd_cmd) && !ilv
        |-> col_addr == COL_W'($past(col_addr) + 1'b1));

    // R4
    ilv_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && $past(col_valid) && !$past(rd_cmd) && ilv
        |-> (col_addr >> 3) == ($past(col_addr) >> 3));

    // R6
    stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_stop && !rd_cmd |=> !col_valid);

    // R7
    cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd && !illegal |=> col_valid && col_addr == $past(start_col));

    // R8
    lat_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat == 3'd1 |-> data_valid == col_valid);

    // R8
    lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat == 3'd2 |-> data_valid == $past(col_valid));

    // R8
    lat_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat == 3'd3 |-> data_valid == $past(col_valid, 2));

    // R1
    load_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_load && (col_valid || rd_cmd) |=> cfg_error);

    // R9
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !col_valid && !data_valid && cfg_error);

endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_load (mode_load),
    .rd_cmd    (rd_cmd),
    .start_col (start_col),
    .burst_stop(burst_stop),
    .col_addr  (col_addr),
    .col_valid (col_valid),
    .data_valid(data_valid),
    .cfg_error (cfg_error),
    .lat       (mode_q.lat),
    .ilv       (mode_q.inter),
    .illegal   (cfg_illegal)
);

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_load = 1'b0;
    logic [6:0] mode_word = '0;
    logic       rd_cmd = 1'b0;
    logic [7:0] start_col = '0;
    logic       burst_stop = 1'b0;
    logic [7:0] col_addr;
    logic       col_valid;
    logic       data_valid;
    logic       cfg_error;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    burst_col_seq i_burst_col_seq (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .rd_cmd(rd_cmd), .start_col(start_col), .burst_stop(burst_stop),
        .col_addr(col_addr), .col_valid(col_valid), .data_valid(data_valid),
        .cfg_error(cfg_error)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit word_bad(input logic [6:0] m);
        bit lbad, bbad;
        lbad = !(m[6:4] inside {3'd1, 3'd2, 3'd3});
        if (m[3]) bbad = !(m[2:0] inside {3'b010, 3'b011});
        else      bbad = !(m[2:0] inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111});
        return lbad || bbad;
    endfunction

    task automatic load(input logic [6:0] m, input string req);
        mode_word = m;
        mode_load = 1'b1;
        @(negedge clk);
        mode_load = 1'b0;
        chk(cfg_error == word_bad(m), req, cfg_error, word_bad(m));
    endtask

    // runs one burst; enters and leaves at a negedge with the block idle
    task automatic run_burst(input logic [7:0] s, input int len, input int stop_at,
                             input bit ilv, input int lat, input string req);
        int eff;
        logic [7:0] ea;
        bit ev, ed;
        eff = (stop_at > 0 && stop_at < len) ? stop_at : len;
        rd_cmd = 1'b1;
        start_col = s;
        @(negedge clk);
        rd_cmd = 1'b0;
        for (int i = 0; i < eff + lat + 2; i++) begin
            ev = (i < eff);
            ed = (i - (lat - 1) >= 0) && (i - (lat - 1) < eff);
            ea = ilv ? (s ^ 8'(i & (len - 1))) : 8'(s + i);
            chk(col_valid == ev, {req, " col_valid"}, col_valid, ev);
            if (ev) chk(col_addr == ea, {req, " col_addr"}, col_addr, ea);
            chk(data_valid == ed, "R8 data_valid", data_valid, ed);
            burst_stop = (stop_at > 0 && i == stop_at - 1);
            @(negedge clk);
        end
        burst_stop = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int lens [5];
        logic [2:0] codes [5];
        logic [7:0] starts [4];
        lens = '{1, 2, 4, 8, 100000};
        codes = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b111};
        starts = '{8'h00, 8'h06, 8'hFD, 8'h7B};

        repeat (3) @(negedge clk);
        // R10 reset state
        chk(col_valid == 0, "R10 col_valid", col_valid, 0);
        chk(data_valid == 0, "R10 data_valid", data_valid, 0);
        chk(cfg_error == 0, "R10 cfg_error", cfg_error, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 default word: latency 1, incrementing, length 1
        run_burst(8'h33, 1, 0, 1'b0, 1, "R10 default");

        // R2 R3 R4 sweep of every legal latency/order/length
        for (int lat = 1; lat <= 3; lat++)
            for (int o = 0; o < 2; o++)
                for (int b = 0; b < 5; b++) begin
                    logic [6:0] m;
                    m = {3'(lat), 1'(o), codes[b]};
                    if (!word_bad(m)) begin
                        load(m, "R2 load legal");
                        foreach (starts[k])
                            run_burst(starts[k], lens[b], (b == 4) ? 12 : 0, o[0], lat,
                                      o ? "R4 interleave" : "R3 increment");
                    end
                end

        // R5 long full page wraps past 256 beats
        load(7'b010_0_111, "R2 load full");
        run_burst(8'h10, 100000, 300, 1'b0, 2, "R5 full page");

        // R6 early stops
        load(7'b001_0_011, "R2 load seq8");
        run_burst(8'hFE, 8, 3, 1'b0, 1, "R6 stop seq");
        load(7'b011_1_011, "R2 load ilv8");
        run_burst(8'hA5, 8, 5, 1'b1, 3, "R6 stop ilv");

        // R7 abort with a simultaneous stop
        load(7'b001_0_011, "R2 load seq8");
        rd_cmd = 1'b1; start_col = 8'h20;
        @(negedge clk);
        rd_cmd = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(col_valid && col_addr == 8'(8'h20 + i), "R7 first burst", col_addr, 8'h20 + i);
            if (i == 2) begin rd_cmd = 1'b1; start_col = 8'hFC; burst_stop = 1'b1; end
            @(negedge clk);
        end
        rd_cmd = 1'b0; burst_stop = 1'b0;
        for (int j = 0; j < 8; j++) begin
            chk(col_valid && col_addr == 8'(8'hFC + j), "R7 restart", col_addr, 8'(8'hFC + j));
            chk(data_valid == 1, "R8 lat1 restart", data_valid, 1);
            @(negedge clk);
        end
        chk(col_valid == 0, "R7 restart end", col_valid, 0);
        repeat (3) @(negedge clk);

        // R1 load refused during a burst and during the latency drain
        load(7'b011_0_111, "R2 load full lat3");
        rd_cmd = 1'b1; start_col = 8'h40;
        @(negedge clk);
        rd_cmd = 1'b0;
        chk(col_addr == 8'h40, "R1 burst start", col_addr, 8'h40);
        @(negedge clk);
        mode_word = 7'b001_1_010; mode_load = 1'b1;
        @(negedge clk);
        mode_load = 1'b0;
        chk(cfg_error == 1, "R1 refused flag", cfg_error, 1);
        chk(col_addr == 8'h42, "R1 order kept", col_addr, 8'h42);
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        chk(cfg_error == 0, "R1 flag one cycle", cfg_error, 0);
        chk(col_valid == 0, "R6 stop", col_valid, 0);
        mode_load = 1'b1;   // pipe still draining
        @(negedge clk);
        mode_load = 1'b0;
        chk(cfg_error == 1, "R1 refused while draining", cfg_error, 1);
        repeat (3) @(negedge clk);
        run_burst(8'h50, 100000, 5, 1'b0, 3, "R1 word unchanged");
        // load together with a read while idle
        mode_word = 7'b001_1_010; mode_load = 1'b1; rd_cmd = 1'b1; start_col = 8'h08;
        @(negedge clk);
        mode_load = 1'b0; rd_cmd = 1'b0;
        chk(cfg_error == 1, "R1 refused with read", cfg_error, 1);
        chk(col_valid && col_addr == 8'h08, "R1 read still runs", col_addr, 8'h08);
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        repeat (4) @(negedge clk);
        run_burst(8'h08, 100000, 6, 1'b0, 3, "R1 word unchanged");

        // R9 every configuration word
        for (int w = 0; w < 128; w++) begin
            load(7'(w), "R9 decode");
            if (word_bad(7'(w))) begin
                rd_cmd = 1'b1; start_col = 8'h11;
                @(negedge clk);
                rd_cmd = 1'b0;
                chk(col_valid == 0, "R9 read ignored", col_valid, 0);
                @(negedge clk);
                chk(col_valid == 0 && data_valid == 0, "R9 read ignored", col_valid, 0);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule